// File: doc/BRIEF.md
# HDLC Receive Deframer with Station Address Filter

This block takes a serial line that has already been sampled, one bit per cycle in which `bit_en` is high, and turns it back into frames. It looks for the boundary pattern 01111110 and removes the zero that a transmitter inserts after five ones. It collects the bits into octets, least significant bit first, and runs the CRC-16-CCITT over each frame. It keeps a frame only if its first octet equals the programmed station address or the broadcast value 0xFF. The two FCS octets are stripped. Every octet that is kept goes into a receive FIFO with four status bits beside it.

Seven or more ones in a row end a frame as aborted. Fifteen or more ones in a row raise the line-idle output. Frames shorter than four octets are dropped without trace.

The host reads the FIFO one entry at a time. It stops at the entry flagged end-of-frame, and that entry carries the frame's verdict: CRC good, aborted, or overflowed. An active-low interrupt asks for service when a complete frame is waiting or when the fill level reaches a threshold.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the FIFO is empty, `rd_valid` is 0, `irq_n` is 1 and `line_idle` is 0. Flags with no octets between them produce no FIFO entries.
- R2: Inside a frame, a 0 that follows five received 1s is deleted. Payload octets that contain runs of ones, including 0x7E and 0xFF, come out of the FIFO unchanged.
- R3: The CRC-16-CCITT is run over every frame octet, including both FCS octets. The generator is reflected 0x8408, the seed is 0xFFFF, and a correct frame leaves residue 0xF0B8. A frame that passes has `crc_ok`=1 on its end-of-frame entry. A frame whose FCS is wrong is still delivered, with `crc_ok`=0.
- R4: The first octet of a frame is compared with `station_addr` and with 0xFF. If it matches neither, the frame writes no FIFO entry.
- R5: A frame closed by a flag after 1 to 3 octets is discarded and writes no FIFO entry.
- R6: A frame of N octets (N ≥ 4) writes N−2 entries, because its FCS is stripped. Only the last of these entries has `eof`=1. The `crc_ok`, `abort` and `ovf` bits can be set only on an `eof` entry.
- R7: A run of seven 1s inside a frame of at least 4 octets ends the frame. Its final entry has `eof`=1, `abort`=1 and `crc_ok`=0. The block then waits for a new flag.
- R8: `line_idle` rises on the bit that completes a run of fifteen 1s. It falls on the next received 0.
- R9: A data entry is written only while at least two FIFO slots are free. Once one octet of a frame has been dropped, all later data octets of that frame are dropped too. The frame's end-of-frame entry is still written with `ovf`=1, and the host is to discard that frame.
- R10: `irq_n` is 0 while the FIFO holds an `eof` entry or holds at least `IRQ_LEVEL` entries, and 1 otherwise. It follows the FIFO state with a lag of up to two cycles.
- R11: A one-cycle `rd_en` while the FIFO is not empty pops the oldest entry. That entry appears with `rd_valid`=1 on the next cycle. `rd_en` while the FIFO is empty is ignored.
- R12: A frame whose bit count between flags is not a multiple of eight is reported with `crc_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Marks a cycle that carries a received line bit |
| bit_in | input | 1 | Received line bit |
| station_addr | input | 8 | Own station address compared against octet one |
| rd_en | input | 1 | Pop request for the oldest FIFO entry |
| rd_valid | output | 1 | Popped entry is on the read outputs this cycle |
| rd_data | output | 8 | Received octet |
| rd_eof | output | 1 | Entry is the last one of its frame |
| rd_crc_ok | output | 1 | Frame passed the FCS check (eof entries only) |
| rd_abort | output | 1 | Frame ended by an abort (eof entries only) |
| rd_ovf | output | 1 | Frame lost octets to a full FIFO (eof entries only) |
| rx_empty | output | 1 | FIFO holds no entries |
| line_idle | output | 1 | Fifteen or more consecutive ones seen |
| irq_n | output | 1 | Active-low service request |

## Verification
The bench sends payloads full of 0x7E and 0xFF. A receiver that deletes the wrong zero, or mistakes a stuffed run for a flag, returns shifted or truncated octets. It corrupts the FCS, ends a frame on a non-octet boundary and sends a three-octet frame. A design that skips the residue test, the alignment test or the length test would report such frames as good or leave stray entries. Foreign-address, aborted and overflowing frames are each followed through to the last entry. A missing end-of-frame entry, or a wrong status bit on it, shows up as a wrong entry count or a wrong flag. The interrupt is checked in three situations: with a finished frame queued, with an unfinished frame filled past the threshold, and after the FIFO has been drained.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_SEED     = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD     = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [7:0]  BCAST_ADDR   = 8'hFF;

  // Line run lengths that carry meaning.
  localparam int STUFF_RUN  = 5;
  localparam int ABORT_RUN  = 7;
  localparam int IDLE_RUN   = 15;
  localparam int ONES_W     = $clog2(IDLE_RUN + 1);

  // Frame sizing: address, control and a two-octet FCS.
  localparam int MIN_BYTES  = 4;
  localparam int HOLD_BYTES = MIN_BYTES - 1;

  // Bits of a closing flag that enter the octet assembler before it is recognised.
  localparam logic [2:0] FLAG_TAIL_BITS = 3'(STUFF_RUN + 1);

  typedef struct packed {
    logic       ovf;
    logic       abort;
    logic       crc_ok;
    logic       eof;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [15:0] crc_step_byte(input logic [15:0] crc_in,
                                                input logic [7:0]  octet);
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ octet[i]) c = (c >> 1) ^ CRC_POLY_REV;
      else                 c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic dbit_vld,
  output logic dbit,
  output logic flag_seen,
  output logic abort_seen,
  output logic idle_line
);

  localparam logic [ONES_W-1:0] RUN_STUFF    = ONES_W'(STUFF_RUN);
  localparam logic [ONES_W-1:0] RUN_FLAG     = ONES_W'(STUFF_RUN + 1);
  localparam logic [ONES_W-1:0] RUN_ABORT_M1 = ONES_W'(ABORT_RUN - 1);
  localparam logic [ONES_W-1:0] RUN_IDLE_M1  = ONES_W'(IDLE_RUN - 1);
  localparam logic [ONES_W-1:0] RUN_MAX      = '1;

  logic [ONES_W-1:0] ones_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q     <= '0;
      dbit_vld   <= 1'b0;
      dbit       <= 1'b0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      idle_line  <= 1'b0;
    end else begin
      dbit_vld   <= 1'b0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      if (bit_en) begin
        if (bit_in) begin
          if (ones_q != RUN_MAX) ones_q <= ones_q + 1'b1;
          // A one is data only while the run stays within the stuffing limit.
          if (ones_q < RUN_STUFF) begin
            dbit_vld <= 1'b1;
            dbit     <= 1'b1;
          end
          if (ones_q == RUN_ABORT_M1) abort_seen <= 1'b1;
          if (ones_q == RUN_IDLE_M1)  idle_line  <= 1'b1;
        end else begin
          ones_q    <= '0;
          idle_line <= 1'b0;
          if (ones_q == RUN_FLAG) begin
            flag_seen <= 1'b1;
          end else if (ones_q < RUN_STUFF) begin
            dbit_vld <= 1'b1;
            dbit     <= 1'b0;
          end
          // ones_q == RUN_STUFF: stuffed zero, dropped.
          // Longer runs end in a zero that carries nothing.
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dbit_vld,
  input  logic       dbit,
  input  logic       flag_seen,
  input  logic       abort_seen,
  input  logic [7:0] station_addr,
  input  logic       room_data,
  input  logic       room_eof,
  output logic       wr_en,
  output rx_entry_t  wr_entry
);

  localparam int CNT_W = $clog2(MIN_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MIN_BYTES);
  localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(HOLD_BYTES);

  logic             active_q;
  logic [CNT_W-1:0] nbytes_q;
  logic [2:0]       nbits_q;
  logic [7:0]       shift_q;
  logic [15:0]      crc_q;
  logic             match_q;
  logic             lost_q;
  logic [7:0]       hold_q [HOLD_BYTES];

  logic [7:0] new_byte;
  logic       frame_long;
  logic       hold_ready;
  logic       addr_hit;

  assign new_byte   = {dbit, shift_q[7:1]};
  assign frame_long = (nbytes_q >= FULL_CNT);
  assign hold_ready = (nbytes_q >= HOLD_CNT);
  assign addr_hit   = (new_byte == station_addr) || (new_byte == BCAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      nbytes_q <= '0;
      nbits_q  <= '0;
      shift_q  <= '0;
      crc_q    <= CRC_SEED;
      match_q  <= 1'b0;
      lost_q   <= 1'b0;
      wr_en    <= 1'b0;
      wr_entry <= '0;
      for (int i = 0; i < HOLD_BYTES; i++) hold_q[i] <= '0;
    end else begin
      wr_en <= 1'b0;
      if (flag_seen) begin
        // Close the running frame (if it qualifies), then open a new one.
        if (active_q && frame_long && match_q && room_eof) begin
          wr_en           <= 1'b1;
          wr_entry.data   <= hold_q[0];
          wr_entry.eof    <= 1'b1;
          wr_entry.crc_ok <= (crc_q == CRC_GOOD) && (nbits_q == FLAG_TAIL_BITS);
          wr_entry.abort  <= 1'b0;
          wr_entry.ovf    <= lost_q;
        end
        active_q <= 1'b1;
        nbytes_q <= '0;
        nbits_q  <= '0;
        crc_q    <= CRC_SEED;
        match_q  <= 1'b0;
        lost_q   <= 1'b0;
      end else if (abort_seen) begin
        if (active_q && frame_long && match_q && room_eof) begin
          wr_en           <= 1'b1;
          wr_entry.data   <= hold_q[0];
          wr_entry.eof    <= 1'b1;
          wr_entry.crc_ok <= 1'b0;
          wr_entry.abort  <= 1'b1;
          wr_entry.ovf    <= lost_q;
        end
        active_q <= 1'b0;
      end else if (dbit_vld && active_q) begin
        shift_q <= new_byte;
        nbits_q <= nbits_q + 1'b1;
        if (nbits_q == 3'd7) begin
          crc_q <= crc_step_byte(crc_q, new_byte);
          if (nbytes_q == '0) match_q <= addr_hit;
          if (!frame_long) nbytes_q <= nbytes_q + 1'b1;
          for (int i = 0; i < HOLD_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
          hold_q[HOLD_BYTES-1] <= new_byte;
          // The oldest held octet is now known not to be FCS.
          if (hold_ready && match_q) begin
            if (room_data && !lost_q) begin
              wr_en    <= 1'b1;
              wr_entry <= '{ovf: 1'b0, abort: 1'b0, crc_ok: 1'b0, eof: 1'b0, data: hold_q[0]};
            end else begin
              lost_q <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IRQ_LEVEL = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  output logic      room_data,
  output logic      room_eof,
  output logic      rd_valid,
  output rx_entry_t rd_entry,
  output logic      empty,
  output logic      irq_n
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] LIM_DATA = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LIM_IRQ  = CNT_W'(IRQ_LEVEL);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] level_q, eofs_q;
  logic [CNT_W-1:0] level_ahead;
  logic             rd_fire;
  logic             eof_in, eof_out;

  assign rd_fire     = rd_en && (level_q != '0);
  assign level_ahead = level_q + {{(CNT_W-1){1'b0}}, wr_en};
  assign room_data   = (level_ahead <= LIM_DATA);
  assign room_eof    = (level_ahead <  LIM_FULL);
  assign empty       = (level_q == '0);
  assign eof_in      = wr_en && wr_entry.eof;
  assign eof_out     = rd_valid && rd_entry.eof;

  // Storage and output register, no reset, so a block RAM fits.
  always_ff @(posedge clk) begin
    if (wr_en)   mem[wptr_q] <= wr_entry;
    if (rd_fire) rd_entry    <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      level_q  <= '0;
      eofs_q   <= '0;
      rd_valid <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      rd_valid <= rd_fire;
      if (wr_en)   wptr_q <= wptr_q + 1'b1;
      if (rd_fire) rptr_q <= rptr_q + 1'b1;
      case ({wr_en, rd_fire})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      case ({eof_in, eof_out})
        2'b10:   eofs_q <= eofs_q + 1'b1;
        2'b01:   eofs_q <= eofs_q - 1'b1;
        default: eofs_q <= eofs_q;
      endcase
      irq_n <= !((eofs_q != '0) || (level_q >= LIM_IRQ));
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IRQ_LEVEL = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic [7:0] station_addr,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_eof,
  output logic       rd_crc_ok,
  output logic       rd_abort,
  output logic       rd_ovf,
  output logic       rx_empty,
  output logic       line_idle,
  output logic       irq_n
);

  logic      dbit_vld, dbit, flag_seen, abort_seen;
  logic      room_data, room_eof, wr_en;
  rx_entry_t wr_entry, rd_entry;

  hdlc_rx_bitproc u_bitproc (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .dbit_vld   (dbit_vld),
    .dbit       (dbit),
    .flag_seen  (flag_seen),
    .abort_seen (abort_seen),
    .idle_line  (line_idle)
  );

  hdlc_rx_framer u_framer (
    .clk          (clk),
    .rst          (rst),
    .dbit_vld     (dbit_vld),
    .dbit         (dbit),
    .flag_seen    (flag_seen),
    .abort_seen   (abort_seen),
    .station_addr (station_addr),
    .room_data    (room_data),
    .room_eof     (room_eof),
    .wr_en        (wr_en),
    .wr_entry     (wr_entry)
  );

  hdlc_rx_fifo #(
    .DEPTH     (DEPTH),
    .IRQ_LEVEL (IRQ_LEVEL)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry),
    .rd_en     (rd_en),
    .room_data (room_data),
    .room_eof  (room_eof),
    .rd_valid  (rd_valid),
    .rd_entry  (rd_entry),
    .empty     (rx_empty),
    .irq_n     (irq_n)
  );

  assign rd_data   = rd_entry.data;
  assign rd_eof    = rd_entry.eof;
  assign rd_crc_ok = rd_entry.crc_ok;
  assign rd_abort  = rd_entry.abort;
  assign rd_ovf    = rd_entry.ovf;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic bit_in,
  input logic rd_en,
  input logic rd_valid,
  input logic rd_eof,
  input logic rd_crc_ok,
  input logic rd_abort,
  input logic rd_ovf,
  input logic rx_empty,
  input logic line_idle,
  input logic irq_n
);

  assert_rd_after_req_R11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !rx_empty));

  assert_empty_read_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_empty) |=> !rd_valid);

  assert_irq_released_when_drained_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_empty, 2) && $past(rx_empty) && rx_empty) |-> irq_n);

  assert_irq_needs_entries_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> !$past(rx_empty));

  assert_idle_rise_on_one_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(line_idle) |-> $past(bit_en && bit_in));

  assert_idle_fall_on_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(line_idle) |-> $past(bit_en && !bit_in));

  assert_status_only_on_eof_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && (rd_abort || rd_ovf || rd_crc_ok)) |-> rd_eof);

  assert_abort_never_good_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_abort) |-> !rd_crc_ok);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .bit_in    (bit_in),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .rd_eof    (rd_eof),
  .rd_crc_ok (rd_crc_ok),
  .rd_abort  (rd_abort),
  .rd_ovf    (rd_ovf),
  .rx_empty  (rx_empty),
  .line_idle (line_idle),
  .irq_n     (irq_n)
);

// File: tb/hdlc_rx_deframer_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;

  localparam int DEPTH     = 16;
  localparam int IRQ_LEVEL = 8;
  localparam logic [7:0] MY_ADDR = 8'h5A;
  localparam int WATCHDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] station_addr = MY_ADDR;
  logic       rd_en = 1'b0;
  logic       rd_valid, rd_eof, rd_crc_ok, rd_abort, rd_ovf, rx_empty, line_idle, irq_n;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  hdlc_rx_deframer #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .station_addr(station_addr),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
    .rd_crc_ok(rd_crc_ok), .rd_abort(rd_abort), .rd_ovf(rd_ovf), .rx_empty(rx_empty),
    .line_idle(line_idle), .irq_n(irq_n)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  int  tx_ones  = 0;
  logic [7:0] fb [64];
  int  n_got;
  logic [7:0] got_d [64];
  bit  got_eof [64];
  bit  got_crc [64];
  bit  got_abt [64];
  bit  got_ovf [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_stuffed(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_stuffed(v[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_body(input int len);
    for (int i = 0; i < len; i++) send_octet(fb[i]);
  endtask

  task automatic send_frame(input int len, input bit bad_fcs, input int extra_bits);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) c = crc_byte(c, fb[i]);
    c = ~c;
    if (bad_fcs) c[3] = ~c[3];
    send_flag();
    send_body(len);
    send_octet(c[7:0]);
    send_octet(c[15:8]);
    for (int i = 0; i < extra_bits; i++) send_stuffed(i[0]);
    send_flag();
    repeat (10) @(negedge clk);
  endtask

  task automatic read_all();
    n_got = 0;
    while (!rx_empty && n_got < 64) begin
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (!rd_valid) break;
      got_d[n_got]   = rd_data;
      got_eof[n_got] = rd_eof;
      got_crc[n_got] = rd_crc_ok;
      got_abt[n_got] = rd_abort;
      got_ovf[n_got] = rd_ovf;
      n_got++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_entries(input int n_exp, input int last_idx, input bit e_crc,
                                input bit e_abort, input bit e_ovf, input string req);
    int bad_d;
    int bad_e;
    bad_d = 0;
    bad_e = 0;
    chk(n_got == n_exp, req, "entry count", n_got, n_exp);
    if (n_got == n_exp && n_exp > 0) begin
      for (int i = 0; i < n_exp - 1; i++) begin
        if (got_d[i] != fb[i]) bad_d++;
        if (got_eof[i] || got_crc[i] || got_abt[i] || got_ovf[i]) bad_e++;
      end
      chk(bad_d == 0, req, "payload mismatches", bad_d, 0);
      chk(bad_e == 0 && got_eof[n_exp-1], "R6", "eof only on last entry", bad_e, 0);
      chk(got_d[n_exp-1] == fb[last_idx], req, "last octet", got_d[n_exp-1], fb[last_idx]);
      chk(got_crc[n_exp-1] == e_crc, req, "crc_ok", got_crc[n_exp-1], e_crc);
      chk(got_abt[n_exp-1] == e_abort, req, "abort", got_abt[n_exp-1], e_abort);
      chk(got_ovf[n_exp-1] == e_ovf, req, "ovf", got_ovf[n_exp-1], e_ovf);
    end
  endtask

  task automatic t_reset();
    chk(rx_empty == 1'b1, "R1", "empty after reset", rx_empty, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(irq_n == 1'b1, "R1", "irq_n after reset", irq_n, 1);
    chk(line_idle == 1'b0, "R1", "line_idle after reset", line_idle, 0);
  endtask

  task automatic t_flags_only();
    for (int i = 0; i < 4; i++) send_flag();
    repeat (10) @(negedge clk);
    chk(rx_empty == 1'b1, "R1", "flags alone leave fifo empty", rx_empty, 1);
  endtask

  task automatic t_good_frame();
    fb[0] = MY_ADDR; fb[1] = 8'h13; fb[2] = 8'h7E; fb[3] = 8'hFF; fb[4] = 8'h00; fb[5] = 8'hF8;
    send_frame(6, 1'b0, 0);
    chk(irq_n == 1'b0, "R10", "irq with frame queued", irq_n, 0);
    read_all();
    verify_entries(6, 5, 1'b1, 1'b0, 1'b0, "R2");
    chk(irq_n == 1'b1, "R10", "irq released after drain", irq_n, 1);
  endtask

  task automatic t_addresses();
    fb[0] = 8'hFF; fb[1] = 8'h03; fb[2] = 8'hA5; fb[3] = 8'h3C;
    send_frame(4, 1'b0, 0);
    read_all();
    verify_entries(4, 3, 1'b1, 1'b0, 1'b0, "R4");
    fb[0] = 8'h33; fb[1] = 8'h03; fb[2] = 8'h11;
    send_frame(3, 1'b0, 0);
    chk(rx_empty == 1'b1, "R4", "foreign address dropped", rx_empty, 1);
  endtask

  task automatic t_bad_fcs();
    fb[0] = MY_ADDR; fb[1] = 8'h10; fb[2] = 8'h99; fb[3] = 8'h42;
    send_frame(4, 1'b1, 0);
    read_all();
    verify_entries(4, 3, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_short();
    fb[0] = MY_ADDR; fb[1] = 8'h01; fb[2] = 8'h77;
    send_flag();
    send_body(3);
    send_flag();
    repeat (10) @(negedge clk);
    chk(rx_empty == 1'b1, "R5", "three-octet frame dropped", rx_empty, 1);
    chk(irq_n == 1'b1, "R5", "no irq for short frame", irq_n, 1);
  endtask

  task automatic t_abort();
    fb[0] = MY_ADDR; fb[1] = 8'h21; fb[2] = 8'h5E; fb[3] = 8'h6F; fb[4] = 8'h70; fb[5] = 8'h81;
    send_flag();
    send_body(6);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    tx_ones = 0;
    repeat (10) @(negedge clk);
    read_all();
    verify_entries(4, 3, 1'b0, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_idle();
    send_bit(1'b0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk(line_idle == 1'b0, "R8", "idle after 14 ones", line_idle, 0);
    send_bit(1'b1);
    chk(line_idle == 1'b1, "R8", "idle after 15 ones", line_idle, 1);
    send_bit(1'b0);
    chk(line_idle == 1'b0, "R8", "idle cleared by zero", line_idle, 0);
    tx_ones = 0;
  endtask

  task automatic t_misaligned();
    fb[0] = MY_ADDR; fb[1] = 8'h44; fb[2] = 8'h12; fb[3] = 8'h34;
    send_frame(4, 1'b0, 3);
    read_all();
    chk(n_got > 0 && got_eof[n_got-1], "R12", "misaligned frame ends with eof", n_got, 1);
    chk(n_got > 0 && !got_crc[n_got-1], "R12", "misaligned frame crc_ok", n_got > 0 ? got_crc[n_got-1] : 1'b1, 0);
  endtask

  task automatic t_overflow();
    fb[0] = MY_ADDR;
    for (int i = 1; i < 20; i++) fb[i] = 8'(i * 7 + 3);
    send_frame(20, 1'b0, 0);
    chk(irq_n == 1'b0, "R10", "irq with full fifo", irq_n, 0);
    read_all();
    verify_entries(DEPTH, 19, 1'b1, 1'b0, 1'b1, "R9");
    chk(rx_empty == 1'b1, "R9", "fifo empty after draining", rx_empty, 1);
  endtask

  task automatic t_threshold();
    fb[0] = MY_ADDR;
    for (int i = 1; i < 12; i++) fb[i] = 8'(8'hC0 + i);
    send_flag();
    send_body(12);
    repeat (10) @(negedge clk);
    chk(irq_n == 1'b0, "R10", "irq at fill threshold without eof", irq_n, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    tx_ones = 0;
    repeat (10) @(negedge clk);
    read_all();
    verify_entries(10, 9, 1'b0, 1'b1, 1'b0, "R10");
  endtask

  task automatic t_empty_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R11", "read of empty fifo ignored", rd_valid, 0);
    chk(rx_empty == 1'b1, "R11", "still empty", rx_empty, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_flags_only();
    t_good_frame();
    t_addresses();
    t_bad_fcs();
    t_short();
    t_abort();
    t_idle();
    t_misaligned();
    t_overflow();
    t_threshold();
    t_empty_read();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule